// File: doc/BRIEF.md
# Prescaled Countdown Timer With Expiry Flag

This block is an 8-bit down-counter whose decrement rate is picked from four prescaled ticks. The ticks come from a free-running divider that counts single-cycle pulses on a reference input. The reference input carries an enable at 32.768 kHz. With the default parameters the four ticks run at 4096 Hz, 64 Hz, 1 Hz and one per minute. The minute tick is made by counting sixty one-hertz ticks.

Software writes a start value. The counter is loaded with it at once and then counts down on each selected tick while the enable bit is set. When the counter reaches its end it reloads the start value on the same tick and sets a sticky expiry flag. An active-low interrupt output either follows the flag as a level or gives a one-clock pulse at each expiry. A small register port writes the control, the start value and the flag clear. A combinational read port returns the control, the live count and the flag.

Top module: `tmr_countdown`

## Requirements
- R1: After reset the control register is 0 (fastest rate, disabled, level mode), the start value and the count are 0, the flag is 0 and irq_n is 1.
- R2: A write to address 1 stores wr_data as the start value and loads it into the count at the same edge. Reading address 1 returns the live count.
- R3: Control bits [1:0] select the tick, with a divider that counts ref_pulse from reset. 0 gives one tick per 2^FAST_SHIFT pulses, 1 gives one per 2^MID_SHIFT, 2 gives one per 2^SLOW_SHIFT, and 3 gives one every MIN_COUNT of the slow ticks.
- R4: While control bit 2 (enable) is 1, each selected tick lowers a count above 1 by exactly one.
- R5: A selected tick that finds the count at 1 or 0 while enabled reloads the start value and sets the flag at the same edge.
- R6: The flag stays set until a write to address 2 with wr_data[0]=1. Other writes leave it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R7: With control bit 3 at 0 (level mode), irq_n is low exactly while the flag is set.
- R8: With control bit 3 at 1 (pulse mode), irq_n is low for exactly the one clock after each expiry edge, whatever the flag holds.
- R9: While the enable is 0 the count holds its value, however many ticks arrive, and no expiry occurs.
- R10: Reading address 0 returns the control bits in rd_data[3:0], with zeros above. Reading address 2 returns the flag in bit 0. Reading address 3 returns 0. A write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | Single-cycle reference enable (32.768 kHz nominal) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 start value, 2 flag clear |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W | Read data, combinational on rd_addr |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the timer with FAST_SHIFT=1, MID_SHIFT=2, SLOW_SHIFT=3 and MIN_COUNT=3. With these values the slowest rate needs only 24 reference pulses per tick, so the minute-rate path and its counter wrap both occur many times within a short run. The small periods also let short start values expire often. This makes reload, set-versus-clear collisions and back-to-back pulse-mode expiries common under random stimulus.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    RATE_FAST = 2'd0,
    RATE_MID  = 2'd1,
    RATE_SLOW = 2'd2,
    RATE_MIN  = 2'd3
  } rate_e;

  typedef struct packed {
    logic  pulse_mode;
    logic  enable;
    rate_e rate;
  } ctrl_t;

  localparam int CTRL_W = 4;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_START = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;
  localparam logic [1:0] ADDR_NONE  = 2'd3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import tmr_pkg::*;
#(
  parameter int FAST_SHIFT = 3,
  parameter int MID_SHIFT  = 9,
  parameter int SLOW_SHIFT = 15,
  parameter int MIN_COUNT  = 60
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ref_pulse,
  input  rate_e rate_sel,
  output logic  tick_sel,
  output logic  tick_slow,
  output logic  tick_min
);

  localparam int MW = (MIN_COUNT > 1) ? $clog2(MIN_COUNT) : 1;
  localparam logic [MW-1:0] MIN_LAST = MW'(MIN_COUNT - 1);

  logic [SLOW_SHIFT-1:0] pre_q;
  logic [MW-1:0]         min_q;
  logic [2:0]            tap;

  function automatic int shift_of(input int idx);
    case (idx)
      0:       return FAST_SHIFT;
      1:       return MID_SHIFT;
      default: return SLOW_SHIFT;
    endcase
  endfunction

  // True when the low n bits of v are all ones (divider about to wrap them).
  function automatic logic low_bits_full(input logic [SLOW_SHIFT-1:0] v, input int n);
    logic r;
    r = 1'b1;
    for (int i = 0; i < SLOW_SHIFT; i++) begin
      if (i < n) r = r & v[i];
    end
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (ref_pulse) pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < 3; g++) begin : g_tap
    assign tap[g] = ref_pulse & low_bits_full(pre_q, shift_of(g));
  end

  assign tick_slow = tap[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) min_q <= '0;
    else if (tick_slow) min_q <= (min_q == MIN_LAST) ? '0 : min_q + 1'b1;
  end

  assign tick_min = tick_slow & (min_q == MIN_LAST);

  always_comb begin
    case (rate_sel)
      RATE_FAST: tick_sel = tap[0];
      RATE_MID:  tick_sel = tap[1];
      RATE_SLOW: tick_sel = tap[2];
      default:   tick_sel = tick_min;
    endcase
  end

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output logic [CNT_W-1:0] start_q,
  output logic             load,
  output logic             flag_clr
);

  logic ctrl_we;

  assign ctrl_we  = wr_en && (wr_addr == ADDR_CTRL);
  assign load     = wr_en && (wr_addr == ADDR_START);
  assign flag_clr = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      start_q <= '0;
    end else begin
      if (ctrl_we) ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (load)    start_q <= wr_data;
    end
  end

endmodule

// File: rtl/tmr_downcnt.sv
module tmr_downcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] start_q,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             expire
);

  function automatic logic at_end(input logic [CNT_W-1:0] v);
    return v <= CNT_W'(1);
  endfunction

  assign expire = step && at_end(cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (expire) cnt_q <= start_q;
    else if (step)   cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (expire)   flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end

endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic flag_q,
  input  logic pulse_mode,
  output logic irq_n
);

  logic pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= expire;
  end

  assign irq_n = pulse_mode ? ~pulse_q : ~flag_q;

endmodule

// File: rtl/tmr_countdown.sv
module tmr_countdown
  import tmr_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int FAST_SHIFT = 3,
  parameter int MID_SHIFT  = 9,
  parameter int SLOW_SHIFT = 15,
  parameter int MIN_COUNT  = 60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             irq_n
);

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] start_q;
  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             flag_clr;
  logic             flag_q;
  logic             tick_sel;
  logic             tick_slow;
  logic             tick_min;
  logic             step;
  logic             expire;
  logic             enable;
  logic             pulse_mode;

  assign enable     = ctrl_q.enable;
  assign pulse_mode = ctrl_q.pulse_mode;
  assign step       = tick_sel && enable;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .start_q  (start_q),
    .load     (load),
    .flag_clr (flag_clr)
  );

  tmr_prescaler #(
    .FAST_SHIFT (FAST_SHIFT),
    .MID_SHIFT  (MID_SHIFT),
    .SLOW_SHIFT (SLOW_SHIFT),
    .MIN_COUNT  (MIN_COUNT)
  ) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .rate_sel  (ctrl_q.rate),
    .tick_sel  (tick_sel),
    .tick_slow (tick_slow),
    .tick_min  (tick_min)
  );

  tmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .load_val (wr_data),
    .start_q  (start_q),
    .flag_clr (flag_clr),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q),
    .expire   (expire)
  );

  tmr_irq u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .expire     (expire),
    .flag_q     (flag_q),
    .pulse_mode (pulse_mode),
    .irq_n      (irq_n)
  );

  function automatic logic [CNT_W-1:0] read_word(input logic [1:0] a, input ctrl_t c,
                                                  input logic [CNT_W-1:0] n, input logic f);
    case (a)
      ADDR_CTRL:  return CNT_W'(c);
      ADDR_START: return n;
      ADDR_FLAG:  return CNT_W'(f);
      default:    return '0;
    endcase
  endfunction

  assign rd_data = read_word(rd_addr, ctrl_q, cnt_q, flag_q);

endmodule

// File: rtl/tmr_countdown_chk.sv
module tmr_countdown_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             irq_n,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] start_q,
  input logic             flag_q,
  input logic             flag_clr,
  input logic             load,
  input logic             step,
  input logic             expire,
  input logic             enable,
  input logic             pulse_mode,
  input logic             tick_slow,
  input logic             tick_min
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_addr == 2'd0);

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |=> cnt_q == $past(wr_data));

  a_r3_min_on_slow: assert property (@(posedge clk) disable iff (!rst_n)
    tick_min |-> tick_slow);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !expire && !load) |=> cnt_q == $past(cnt_q) - 1'b1);

  a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> cnt_q == $past(start_q));

  a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> flag_q);

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !expire) |=> !flag_q);

  a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse_mode && !ctrl_wr && expire) |=> !irq_n);

  a_r8_pulse_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !ctrl_wr && expire) |=> !irq_n);

  a_r8_pulse_off: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_mode && !ctrl_wr && !expire) |=> irq_n);

  a_r9_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load) |=> $stable(cnt_q));

endmodule

bind tmr_countdown tmr_countdown_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .irq_n      (irq_n),
  .cnt_q      (cnt_q),
  .start_q    (start_q),
  .flag_q     (flag_q),
  .flag_clr   (flag_clr),
  .load       (load),
  .step       (step),
  .expire     (expire),
  .enable     (enable),
  .pulse_mode (pulse_mode),
  .tick_slow  (tick_slow),
  .tick_min   (tick_min)
);

// File: tb/tmr_countdown_tb.sv
module tmr_countdown_tb;

  localparam int CW = 8;
  localparam int FS = 1;
  localparam int MS = 2;
  localparam int SS = 3;
  localparam int MC = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ref_pulse = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic [1:0]    rd_addr = '0;
  logic [CW-1:0] rd_data;
  logic          irq_n;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  // bench model state
  int       m_pre, m_min;
  bit [3:0] m_ctrl;
  int       m_start, m_cnt;
  bit       m_flag, m_pulse;

  always #5 clk = ~clk;

  tmr_countdown #(
    .CNT_W(CW), .FAST_SHIFT(FS), .MID_SHIFT(MS), .SLOW_SHIFT(SS), .MIN_COUNT(MC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  function automatic bit period_hit(int count_before, int period);
    return ((count_before + 1) % period) == 0;
  endfunction

  function automatic int exp_read(bit [1:0] a);
    case (a)
      2'd0:    return int'(m_ctrl);
      2'd1:    return m_cnt;
      2'd2:    return int'(m_flag);
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_irq_n();
    return m_ctrl[3] ? !m_pulse : !m_flag;
  endfunction

  task automatic model_reset();
    m_pre = 0; m_min = 0; m_ctrl = '0; m_start = 0; m_cnt = 0;
    m_flag = 0; m_pulse = 0;
  endtask

  task automatic model_step(bit w, bit [1:0] a, int d, bit r);
    bit t_fast, t_mid, t_slow, t_min, t_sel, stp, exp_now;
    t_fast = r && period_hit(m_pre, 1 << FS);
    t_mid  = r && period_hit(m_pre, 1 << MS);
    t_slow = r && period_hit(m_pre, 1 << SS);
    t_min  = t_slow && (m_min == MC - 1);
    case (m_ctrl[1:0])
      2'd0: t_sel = t_fast;
      2'd1: t_sel = t_mid;
      2'd2: t_sel = t_slow;
      default: t_sel = t_min;
    endcase
    stp = t_sel && m_ctrl[2];
    exp_now = stp && (m_cnt <= 1);
    if (r) m_pre = (m_pre + 1) % (1 << SS);
    if (t_slow) m_min = (m_min + 1) % MC;
    if (w && a == 2'd1) begin
      m_start = d; m_cnt = d;
    end else if (exp_now) m_cnt = m_start;
    else if (stp) m_cnt = m_cnt - 1;
    if (w && a == 2'd0) m_ctrl = d[3:0];
    if (exp_now) m_flag = 1;
    else if (w && a == 2'd2 && d[0]) m_flag = 0;
    m_pulse = exp_now;
  endtask

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Entered at a negedge; leaves at the next negedge.
  task automatic cyc(bit w, bit [1:0] a, int d, bit r, bit [1:0] ra);
    string tag;
    wr_en = w; wr_addr = a; wr_data = CW'(d); ref_pulse = r; rd_addr = ra;
    #1;
    case (ra)
      2'd1:    tag = "R4 count";
      2'd2:    tag = "R6 flag";
      default: tag = "R10 read";
    endcase
    check(tag, int'(rd_data), exp_read(ra));
    check(m_ctrl[3] ? "R8 irq" : "R7 irq", int'(irq_n), int'(exp_irq_n()));
    @(posedge clk);
    model_step(w, a, d, r);
    @(negedge clk);
  endtask

  task automatic peek(bit [1:0] ra);
    rd_addr = ra; wr_en = 1'b0; ref_pulse = 1'b0;
    #1;
  endtask

  task automatic run_ref(int n, bit [1:0] ra);
    for (int i = 0; i < n; i++) cyc(0, 2'd0, 0, 1, ra);
  endtask

  task automatic rate_case(string tag, int rate, int refs);
    cyc(1, 2'd0, 4 | rate, 0, 2'd1);
    cyc(1, 2'd1, 100, 0, 2'd1);
    run_ref(refs, 2'd1);
    peek(2'd1);
    check(tag, int'(rd_data), 90);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_7123));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      peek(2'(a));
      check("R1 reset read", int'(rd_data), 0);
    end
    check("R1 reset irq_n", int'(irq_n), 1);

    // R2 load and live read
    cyc(1, 2'd1, 5, 0, 2'd1);
    peek(2'd1);
    check("R2 load count", int'(rd_data), 5);

    // R9 disabled: count frozen under ticks
    cyc(1, 2'd1, 7, 0, 2'd1);
    run_ref(20, 2'd1);
    peek(2'd1);
    check("R9 frozen count", int'(rd_data), 7);
    peek(2'd2);
    check("R9 no flag", int'(rd_data), 0);

    // R3/R4 each rate: ten ticks from a multiple of the period
    rate_case("R3 fast rate", 0, 10 * (1 << FS));
    rate_case("R3 mid rate", 1, 10 * (1 << MS));
    rate_case("R3 slow rate", 2, 10 * (1 << SS));
    rate_case("R3 minute rate", 3, 10 * MC * (1 << SS));

    // R5 expiry reload and flag; R7 level interrupt
    cyc(1, 2'd0, 4, 0, 2'd1);
    cyc(1, 2'd1, 2, 0, 2'd1);
    run_ref(2 * (1 << FS), 2'd1);
    peek(2'd1);
    check("R5 reload value", int'(rd_data), 2);
    peek(2'd2);
    check("R5 flag set", int'(rd_data), 1);
    check("R7 level irq low", int'(irq_n), 0);

    // R6 flag only cleared by addr 2 bit0
    cyc(1, 2'd0, 0, 0, 2'd2);
    cyc(1, 2'd2, 2, 0, 2'd2);
    peek(2'd2);
    check("R6 flag kept", int'(rd_data), 1);
    cyc(1, 2'd2, 1, 0, 2'd2);
    peek(2'd2);
    check("R6 flag cleared", int'(rd_data), 0);
    check("R7 irq released", int'(irq_n), 1);

    // R8 pulse mode: start 1 expires on every tick
    cyc(1, 2'd0, 4'hC, 0, 2'd1);
    cyc(1, 2'd1, 1, 0, 2'd1);
    run_ref(4 * (1 << FS), 2'd2);
    cyc(0, 2'd0, 0, 0, 2'd2);
    peek(2'd2);
    check("R8 pulse ended", int'(irq_n), 1);
    check("R8 flag still set", int'(rd_data), 1);

    // R10 address 3 ignored and reads zero
    cyc(1, 2'd0, 2, 0, 2'd0);
    cyc(1, 2'd3, 8'hFF, 0, 2'd3);
    peek(2'd3);
    check("R10 addr3 read", int'(rd_data), 0);
    peek(2'd0);
    check("R10 ctrl read", int'(rd_data), 2);

    // Random mix
    for (int i = 0; i < 6000; i++) begin
      bit w;
      bit [1:0] a;
      int d;
      w = ($urandom_range(0, 7) == 0);
      a = 2'($urandom_range(0, 3));
      case (a)
        2'd0: d = int'($urandom_range(0, 15)) | (($urandom_range(0, 3) != 0) ? 4 : 0);
        2'd1: d = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 255))
                                               : int'($urandom_range(0, 5));
        default: d = int'($urandom_range(0, 255));
      endcase
      cyc(w, a, d, ($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule